// File: doc/BRIEF.md
# SDRAM Command Spacing Timer

This block sits between an SDRAM command sequencer and the command bus. It keeps three saturating elapsed-cycle counters, one each for the last bank-activate, the last write and the last precharge. It compares them with minimum spacings decoded from small configuration codes. From that comparison it produces three "allowed" flags. The flags say whether a read/write, a precharge or a bank-activate may go out in the current cycle. The sequencer tells the block which commands it issued by pulsing an event input for one cycle per command.

Four configuration values are captured only on cycles where the sequencer reports itself idle:

- the activate-to-column delay code;
- the write-to-precharge delay code;
- the precharge-time code;
- the auto-precharge and reduced-timing mode bits.

Some codes are reserved. Others are forbidden while the reduced-timing mode is selected. The block raises a configuration error whenever the captured combination is illegal.

Top module: `sdram_cmd_spacer`

## Requirements
- R1: After reset every allowed output (`ok_rdwr`, `ok_pre`, `ok_act`) is 1 and `cfg_err` is 0, because the captured configuration resets to activate code 01, write code 000, precharge code 000 and both modes off.
- R2: The 2-bit activate-to-column code gives a delay D of 2, 3 or 4 cycles for codes 01, 10 and 11. The reserved code 00 is timed as 4 cycles.
- R3: If an activate event is sampled at clock edge E, `ok_rdwr` is 0 during the N-th cycle after E for every N < D, and it is 1 from N = D on until the next activate.
- R4: The 3-bit write-to-precharge code c gives a delay W = c+1 for codes 000 to 100. The reserved codes 101, 110 and 111 are timed as 5 cycles. After a write sampled at edge E, `ok_pre` is 0 in the N-th cycle after E exactly when N < W.
- R5: The 3-bit precharge-time code p gives P = p+1 cycles. After a precharge sampled at edge E, `ok_act` is 0 in the N-th cycle after E exactly when N < P.
- R6: With auto-precharge mode captured as 1, after a write sampled at edge E, `ok_act` is 0 in the N-th cycle after E exactly when N < P+W. With the mode captured as 0, a write has no effect on `ok_act`.
- R7: `cfg_err` is 1 when any of the following holds, and 0 otherwise:
  - the activate code is 00;
  - the write code is 101, 110 or 111;
  - reduced-timing mode is set together with activate code 11;
  - reduced-timing mode is set together with write code 010, 011 or 100.
- R8: Configuration inputs are captured only on edges where `seq_idle` is 1. Changes while `seq_idle` is 0 alter neither `cfg_err` nor any spacing.
- R9: Counters saturate. With no events, every allowed output returns to 1 within 13 cycles and stays at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_idle | input | 1 | Sequencer idle; configuration is captured while high |
| ras_down | input | 1 | Reduced-timing mode selection |
| auto_pre | input | 1 | Auto-precharge mode selection |
| rcd_code | input | 2 | Activate-to-column delay code |
| trwl_code | input | 3 | Write-to-precharge delay code |
| tpc_code | input | 3 | Precharge-time code |
| ev_act | input | 1 | Bank-activate issued this cycle |
| ev_wr | input | 1 | Write issued this cycle |
| ev_pre | input | 1 | Precharge issued this cycle |
| ok_rdwr | output | 1 | Read or write currently allowed |
| ok_pre | output | 1 | Precharge currently allowed |
| ok_act | output | 1 | Bank-activate currently allowed |
| cfg_err | output | 1 | Captured configuration is illegal |

## Verification
A counter that restarts at the wrong value, or that wraps instead of saturating, shifts the opening of an allowed flag by one or more cycles. It can also make a flag reopen long after idle. Both show on the first event that follows. A wrong decode of a code shows as a window one or more cycles too short or too long. A capture that ignores `seq_idle` shows as a change in `cfg_err` or in a window length the cycle after the stray update. The bench sweeps every code and mode and measures each window cycle by cycle, so any of these faults shows within one window.

// File: rtl/sdcs_pkg.sv
package sdcs_pkg;
  localparam int RCD_W  = 2;
  localparam int TRWL_W = 3;
  localparam int TPC_W  = 3;
  localparam int TRWL_MAX = 5;
  localparam int MAX_GAP  = (1 << TPC_W) + TRWL_MAX;
  localparam int CNT_W    = $clog2(MAX_GAP + 1);

  typedef struct packed {
    logic [RCD_W-1:0]  rcd;
    logic [TRWL_W-1:0] trwl;
    logic [TPC_W-1:0]  tpc;
    logic              ras_down;
    logic              auto_pre;
  } cfg_t;

  localparam cfg_t CFG_RESET = '{rcd: RCD_W'(1), trwl: '0, tpc: '0,
                                 ras_down: 1'b0, auto_pre: 1'b0};
endpackage

// File: rtl/sdcs_cfg_reg.sv
module sdcs_cfg_reg
  import sdcs_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cap_en,
  input  cfg_t cfg_in,
  output cfg_t cfg_q
);
  cfg_t cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (cap_en) cfg_d = cfg_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= CFG_RESET;
    else        cfg_q <= cfg_d;
  end
endmodule

// File: rtl/sdcs_decode.sv
module sdcs_decode
  import sdcs_pkg::*;
(
  input  cfg_t             cfg,
  output logic [CNT_W-1:0] rcd_cyc,
  output logic [CNT_W-1:0] trwl_cyc,
  output logic [CNT_W-1:0] tpc_cyc,
  output logic [CNT_W-1:0] wr_act_cyc,
  output logic             cfg_err
);
  logic rcd_rsvd, trwl_rsvd, rd_bad;

  always_comb begin
    rcd_rsvd  = (cfg.rcd == '0);
    trwl_rsvd = (int'(cfg.trwl) >= TRWL_MAX);
    // reserved codes are timed with the longest legal spacing
    rcd_cyc  = rcd_rsvd  ? CNT_W'((1 << RCD_W)) : CNT_W'(cfg.rcd) + CNT_W'(1);
    trwl_cyc = trwl_rsvd ? CNT_W'(TRWL_MAX) : CNT_W'(cfg.trwl) + CNT_W'(1);
    tpc_cyc  = CNT_W'(cfg.tpc) + CNT_W'(1);
    wr_act_cyc = tpc_cyc + trwl_cyc;
    rd_bad = cfg.ras_down &&
             ((cfg.rcd == '1) || (int'(cfg.trwl) >= 2 && !trwl_rsvd));
    cfg_err = rcd_rsvd || trwl_rsvd || rd_bad;
  end
endmodule

// File: rtl/sdcs_elapsed.sv
module sdcs_elapsed #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         event_i,
  output logic [W-1:0] count_o
);
  logic [W-1:0] count_d;
  logic         cnt_en;

  always_comb begin
    cnt_en  = event_i || (count_o != '1);
    count_d = event_i ? W'(1) : count_o + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count_o <= '1;
    else if (cnt_en) count_o <= count_d;
  end
endmodule

// File: rtl/sdram_cmd_spacer.sv
module sdram_cmd_spacer
  import sdcs_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              seq_idle,
  input  logic              ras_down,
  input  logic              auto_pre,
  input  logic [RCD_W-1:0]  rcd_code,
  input  logic [TRWL_W-1:0] trwl_code,
  input  logic [TPC_W-1:0]  tpc_code,
  input  logic              ev_act,
  input  logic              ev_wr,
  input  logic              ev_pre,
  output logic              ok_rdwr,
  output logic              ok_pre,
  output logic              ok_act,
  output logic              cfg_err
);
  localparam int N_EV = 3;
  localparam int I_ACT = 0, I_WR = 1, I_PRE = 2;

  cfg_t cfg_in, cfg_q;
  logic [CNT_W-1:0] rcd_cyc, trwl_cyc, tpc_cyc, wr_act_cyc;
  logic [N_EV-1:0]  ev_vec;
  logic [CNT_W-1:0] elapsed [N_EV];
  logic             auto_pre_q;

  assign cfg_in = '{rcd: rcd_code, trwl: trwl_code, tpc: tpc_code,
                    ras_down: ras_down, auto_pre: auto_pre};
  assign ev_vec = {ev_pre, ev_wr, ev_act};
  assign auto_pre_q = cfg_q.auto_pre;

  sdcs_cfg_reg cfg_i (
    .clk(clk), .rst_n(rst_n), .cap_en(seq_idle),
    .cfg_in(cfg_in), .cfg_q(cfg_q)
  );

  sdcs_decode dec_i (
    .cfg(cfg_q), .rcd_cyc(rcd_cyc), .trwl_cyc(trwl_cyc),
    .tpc_cyc(tpc_cyc), .wr_act_cyc(wr_act_cyc), .cfg_err(cfg_err)
  );

  for (genvar g = 0; g < N_EV; g++) begin : g_cnt
    sdcs_elapsed #(.W(CNT_W)) cnt_i (
      .clk(clk), .rst_n(rst_n), .event_i(ev_vec[g]), .count_o(elapsed[g])
    );
  end

  always_comb begin
    ok_rdwr = (elapsed[I_ACT] >= rcd_cyc);
    ok_pre  = (elapsed[I_WR]  >= trwl_cyc);
    ok_act  = (elapsed[I_PRE] >= tpc_cyc) &&
              (!auto_pre_q || (elapsed[I_WR] >= wr_act_cyc));
  end
endmodule

// File: rtl/sdcs_checker.sv
module sdcs_checker (
  input logic clk,
  input logic rst_n,
  input logic seq_idle,
  input logic ev_act,
  input logic ev_wr,
  input logic ev_pre,
  input logic ok_rdwr,
  input logic ok_pre,
  input logic ok_act,
  input logic auto_pre_q
);
  a_r3_rdwr_closed_after_act: assert property (@(posedge clk) disable iff (!rst_n)
    ev_act |=> !ok_rdwr);

  a_r3_rdwr_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_rdwr && !ev_act && !seq_idle) |=> ok_rdwr);

  a_r4_pre_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_pre && !ev_wr && !seq_idle) |=> ok_pre);

  a_r6_act_closed_after_auto_wr: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_wr && auto_pre_q && !seq_idle) |=> !ok_act);

  a_r5_act_stays_open: assert property (@(posedge clk) disable iff (!rst_n)
    (ok_act && !ev_wr && !ev_pre && !seq_idle) |=> ok_act);
endmodule

bind sdram_cmd_spacer sdcs_checker chk_i (
  .clk(clk), .rst_n(rst_n), .seq_idle(seq_idle),
  .ev_act(ev_act), .ev_wr(ev_wr), .ev_pre(ev_pre),
  .ok_rdwr(ok_rdwr), .ok_pre(ok_pre), .ok_act(ok_act),
  .auto_pre_q(auto_pre_q)
);

// File: tb/sdram_cmd_spacer_tb_top.sv
module sdram_cmd_spacer_tb_top;
  logic clk = 1'b0;
  logic rst_n, seq_idle, ras_down, auto_pre, ev_act, ev_wr, ev_pre;
  logic [1:0] rcd_code;
  logic [2:0] trwl_code, tpc_code;
  logic ok_rdwr, ok_pre, ok_act, cfg_err;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  sdram_cmd_spacer dut_i (
    .clk(clk), .rst_n(rst_n), .seq_idle(seq_idle), .ras_down(ras_down),
    .auto_pre(auto_pre), .rcd_code(rcd_code), .trwl_code(trwl_code),
    .tpc_code(tpc_code), .ev_act(ev_act), .ev_wr(ev_wr), .ev_pre(ev_pre),
    .ok_rdwr(ok_rdwr), .ok_pre(ok_pre), .ok_act(ok_act), .cfg_err(cfg_err)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int rcd_d(input int c); return (c == 0) ? 4 : c + 1; endfunction
  function automatic int trwl_d(input int c); return (c > 4) ? 5 : c + 1; endfunction
  function automatic logic err_exp(input int r, input int w, input logic rd);
    return (r == 0) || (w > 4) || (rd && (r == 3 || (w >= 2 && w <= 4)));
  endfunction

  // called at a negedge; returns at a negedge with the new config captured
  task automatic set_cfg(input int r, input int w, input int p, input logic rd, input logic ap);
    rcd_code = 2'(r); trwl_code = 3'(w); tpc_code = 3'(p);
    ras_down = rd; auto_pre = ap; seq_idle = 1'b1;
    @(negedge clk);
    seq_idle = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // pulse one event; afterwards cnt=1 at the current negedge
  task automatic pulse(input int which);
    ev_act = (which == 0); ev_wr = (which == 1); ev_pre = (which == 2);
    @(negedge clk);
    ev_act = 0; ev_wr = 0; ev_pre = 0;
  endtask

  initial begin
    rst_n = 0; seq_idle = 0; ras_down = 0; auto_pre = 0;
    ev_act = 0; ev_wr = 0; ev_pre = 0;
    rcd_code = 0; trwl_code = 7; tpc_code = 7;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state (inputs are reserved but not captured: seq_idle low)
    check("R1 ok_rdwr", ok_rdwr, 1);
    check("R1 ok_pre", ok_pre, 1);
    check("R1 ok_act", ok_act, 1);
    check("R1 cfg_err", cfg_err, 0);

    // R7 error table sweep
    for (int r = 0; r < 4; r++)
      for (int w = 0; w < 8; w++)
        for (int rd = 0; rd < 2; rd++) begin
          set_cfg(r, w, 0, rd[0], 0);
          check("R7 cfg_err", cfg_err, err_exp(r, w, rd[0]));
        end

    // R2/R3 activate-to-column windows
    for (int r = 0; r < 4; r++) begin
      set_cfg(r, 0, 0, 0, 0);
      pulse(0);
      for (int n = 1; n <= 15; n++) begin
        check(n < rcd_d(r) ? "R3 rdwr closed" : "R2 rdwr open", ok_rdwr, n >= rcd_d(r));
        @(negedge clk);
      end
    end

    // R4 write-to-precharge windows, R5 precharge-to-activate
    for (int w = 0; w < 8; w++) begin
      set_cfg(1, w, w, 0, 0);
      pulse(1);
      for (int n = 1; n <= 15; n++) begin
        check("R4 ok_pre", ok_pre, n >= trwl_d(w));
        check("R6 ok_act no auto", ok_act, 1);
        @(negedge clk);
      end
      pulse(2);
      for (int n = 1; n <= 10; n++) begin
        check("R5 ok_act", ok_act, n >= w + 1);
        @(negedge clk);
      end
    end

    // R6 auto-precharge write-to-activate sweep
    for (int p = 0; p < 8; p++)
      for (int w = 0; w < 8; w++) begin
        set_cfg(1, w, p, 0, 1);
        idle(14);
        pulse(1);
        for (int n = 1; n <= 15; n++) begin
          check("R6 ok_act auto", ok_act, n >= p + 1 + trwl_d(w));
          @(negedge clk);
        end
      end

    // R8 changes while busy are ignored
    set_cfg(3, 4, 0, 0, 0);
    check("R8 base err", cfg_err, 0);
    rcd_code = 0; trwl_code = 7; ras_down = 1;
    idle(2);
    check("R8 err unchanged", cfg_err, 0);
    pulse(0);
    for (int n = 1; n <= 6; n++) begin
      check("R8 rcd kept", ok_rdwr, n >= 4);
      @(negedge clk);
    end
    pulse(1);
    for (int n = 1; n <= 7; n++) begin
      check("R8 trwl kept", ok_pre, n >= 5);
      @(negedge clk);
    end

    // R9 saturation: idle long after all events
    set_cfg(3, 4, 7, 0, 1);
    pulse(0); pulse(1); pulse(2);
    idle(40);
    check("R9 ok_rdwr", ok_rdwr, 1);
    check("R9 ok_pre", ok_pre, 1);
    check("R9 ok_act", ok_act, 1);
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule